// File: doc/BRIEF.md
# Base-integer immediate extraction unit

This combinational block takes one 32-bit base-integer instruction word and rebuilds the immediate operand hidden in it. Five signed layouts are in use: upper, jump, register-immediate, branch and store. Each one places its bits at different positions in the word. The block builds every candidate in parallel from fixed bit positions, picks one by the major opcode, and reports which layout it used as a 3-bit format code.

The block also produces the 5-bit shift amount of the shift-immediate forms, and it returns the zero-extended 5-bit operand of the immediate control-register forms. Opcodes that carry no immediate are accepted and give a zero immediate. Any other opcode raises an illegal flag, and so does a shift-immediate word with a bad upper field. A decode stage places the block next to its instruction register and feeds the outputs straight into operand selection.

Top module: `imm_extract`

## Requirements
- R1: Format code encoding on `fmt_o`: 0 unrecognised, 1 register/no immediate, 2 register-immediate (I), 3 store (S), 4 branch (B), 5 upper (U), 6 jump (J), 7 control-register immediate (Z). Opcode is bits 6:0, funct3 is bits 14:12 and funct7 is bits 31:25.
- R2: For opcodes 0110111 and 0010111, `fmt_o`=5 and `imm_o` = instruction bits 31:12 followed by twelve zero bits.
- R3: For opcode 1101111, `fmt_o`=6. `imm_o` bit 20 comes from instruction bit 31, bits 10:1 from 30:21, bit 11 from 20 and bits 19:12 from 19:12. Bit 0 is zero and bits 31:21 copy instruction bit 31.
- R4: For opcode 1100011, `fmt_o`=4. `imm_o` bit 12 comes from instruction bit 31, bits 10:5 from 30:25, bits 4:1 from 11:8 and bit 11 from bit 7. Bit 0 is zero and bits 31:13 copy instruction bit 31.
- R5: For opcode 0100011, `fmt_o`=3. `imm_o` bits 11:5 come from instruction bits 31:25 and bits 4:0 from 11:7, sign-extended from instruction bit 31.
- R6: For opcodes 0000011, 0010011 and 1100111, `fmt_o`=2 and `imm_o` is instruction bits 31:20, sign-extended from bit 31.
- R7: `shamt_o` equals instruction bits 24:20 when opcode is 0010011 and funct3 is 001 or 101 with an accepted funct7. It is zero for every other word.
- R8: Under opcode 0010011, funct3 001 with funct7 other than 0000000 is illegal. Funct3 101 with funct7 other than 0000000 or 0100000 is also illegal.
- R9: For opcode 1110011 with funct3 101, 110 or 111, `fmt_o`=7 and `imm_o` is instruction bits 19:15 zero-extended to 32 bits.
- R10: Opcodes 0110011 and 0001111, and opcode 1110011 with funct3 bit 2 clear, give `fmt_o`=1, `imm_o`=0 and `illegal_o`=0.
- R11: Any other opcode, and any word rejected by R8, gives `illegal_o`=1 with `imm_o`=0, `fmt_o`=0 and `shamt_o`=0.
- R12: The block holds no state. Its outputs depend only on the present instruction word, and bits outside the selected fields leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| imm_o | output | 32 | Rebuilt immediate |
| fmt_o | output | 3 | Format code applied |
| illegal_o | output | 1 | Opcode or shift field not accepted |
| shamt_o | output | 5 | Shift amount of shift-immediate forms |

## Verification
The checks assume the instruction word is a settled 2-state value, and they are evaluated only after the combinational outputs have followed it. They also assume that the format code alone tells which field layout may appear on the immediate output. The bench changes the word once per clock, away from the sampling edge, and uses only defined values. The words cover every major opcode class plus all-zero and all-one words, and single set bits are walked through the upper and register-immediate fields so that every field position is tested on its own.

// File: rtl/imm_pkg.sv
package imm_pkg;

  localparam int INSTR_W = 32;
  localparam int IMM_W   = 32;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;
  localparam int SHAMT_W = 5;
  localparam int ZIMM_W  = 5;

  // opcodes decoded by the classifier
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_FENCE  = 7'b0001111;
  localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [F3_W-1:0] F3_SHL = 3'b001;
  localparam logic [F3_W-1:0] F3_SHR = 3'b101;
  localparam logic [F7_W-1:0] F7_PLAIN = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ARITH = 7'b0100000;

  typedef enum logic [2:0] {
    FMT_BAD = 3'd0,
    FMT_REG = 3'd1,
    FMT_I   = 3'd2,
    FMT_S   = 3'd3,
    FMT_B   = 3'd4,
    FMT_U   = 3'd5,
    FMT_J   = 3'd6,
    FMT_Z   = 3'd7
  } imm_fmt_e;

  typedef struct packed {
    logic [IMM_W-1:0] i_val;
    logic [IMM_W-1:0] s_val;
    logic [IMM_W-1:0] b_val;
    logic [IMM_W-1:0] u_val;
    logic [IMM_W-1:0] j_val;
    logic [IMM_W-1:0] z_val;
  } imm_cand_t;

endpackage

// File: rtl/imm_classify.sv
module imm_classify
  import imm_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [F3_W-1:0]  f3_i,
  input  logic [F7_W-1:0]  f7_i,
  output imm_fmt_e         fmt_o,
  output logic             shift_o
);

  logic shl_ok;
  logic shr_ok;

  assign shl_ok = (f7_i == F7_PLAIN);
  assign shr_ok = (f7_i == F7_PLAIN) || (f7_i == F7_ARITH);

  always_comb begin
    fmt_o   = FMT_BAD;
    shift_o = 1'b0;
    unique case (opc_i)
      OPC_LUI, OPC_AUIPC: fmt_o = FMT_U;
      OPC_JAL:            fmt_o = FMT_J;
      OPC_BRANCH:         fmt_o = FMT_B;
      OPC_STORE:          fmt_o = FMT_S;
      OPC_LOAD, OPC_JALR: fmt_o = FMT_I;
      OPC_OPIMM: begin
        if (f3_i == F3_SHL) begin
          fmt_o   = shl_ok ? FMT_I : FMT_BAD;
          shift_o = shl_ok;
        end else if (f3_i == F3_SHR) begin
          fmt_o   = shr_ok ? FMT_I : FMT_BAD;
          shift_o = shr_ok;
        end else begin
          fmt_o = FMT_I;
        end
      end
      OPC_OP, OPC_FENCE:  fmt_o = FMT_REG;
      OPC_SYSTEM:         fmt_o = f3_i[2] ? FMT_Z : FMT_REG;
      default:            fmt_o = FMT_BAD;
    endcase
  end

endmodule

// File: rtl/imm_field_build.sv
module imm_field_build
  import imm_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output imm_cand_t          cand_o
);

  localparam int I_LEN = 12;
  localparam int S_LEN = 12;
  localparam int B_LEN = 13;
  localparam int J_LEN = 21;
  localparam int U_LOW = 12;

  logic sgn;
  logic [I_LEN-1:0] i_raw;
  logic [S_LEN-1:0] s_raw;
  logic [B_LEN-1:0] b_raw;
  logic [J_LEN-1:0] j_raw;

  assign sgn = instr_i[INSTR_W-1];

  // scattered fields regathered into contiguous raw values
  assign i_raw = instr_i[31:20];
  assign s_raw = {instr_i[31:25], instr_i[11:7]};
  assign b_raw = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
  assign j_raw = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};

  assign cand_o.i_val = {{(IMM_W-I_LEN){sgn}}, i_raw};
  assign cand_o.s_val = {{(IMM_W-S_LEN){sgn}}, s_raw};
  assign cand_o.b_val = {{(IMM_W-B_LEN){sgn}}, b_raw};
  assign cand_o.j_val = {{(IMM_W-J_LEN){sgn}}, j_raw};
  assign cand_o.u_val = {instr_i[31:U_LOW], {U_LOW{1'b0}}};
  assign cand_o.z_val = {{(IMM_W-ZIMM_W){1'b0}}, instr_i[19:15]};

endmodule

// File: rtl/imm_select.sv
module imm_select
  import imm_pkg::*;
(
  input  imm_fmt_e         fmt_i,
  input  imm_cand_t        cand_i,
  output logic [IMM_W-1:0] imm_o
);

  always_comb begin
    unique case (fmt_i)
      FMT_I:   imm_o = cand_i.i_val;
      FMT_S:   imm_o = cand_i.s_val;
      FMT_B:   imm_o = cand_i.b_val;
      FMT_U:   imm_o = cand_i.u_val;
      FMT_J:   imm_o = cand_i.j_val;
      FMT_Z:   imm_o = cand_i.z_val;
      default: imm_o = '0;
    endcase
  end

endmodule

// File: rtl/imm_extract.sv
module imm_extract
  import imm_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [31:0] imm_o,
  output logic [2:0]  fmt_o,
  output logic        illegal_o,
  output logic [4:0]  shamt_o
);

  imm_fmt_e  fmt;
  logic      shift_sel;
  imm_cand_t cand;

  imm_classify u_classify (
    .opc_i   (instr_i[6:0]),
    .f3_i    (instr_i[14:12]),
    .f7_i    (instr_i[31:25]),
    .fmt_o   (fmt),
    .shift_o (shift_sel)
  );

  imm_field_build u_build (
    .instr_i (instr_i),
    .cand_o  (cand)
  );

  imm_select u_select (
    .fmt_i  (fmt),
    .cand_i (cand),
    .imm_o  (imm_o)
  );

  assign fmt_o     = fmt;
  assign illegal_o = (fmt == FMT_BAD);
  assign shamt_o   = shift_sel ? instr_i[24:20] : '0;

endmodule

// File: rtl/imm_extract_chk.sv
module imm_extract_chk (
  input logic [31:0] instr_i,
  input logic [31:0] imm_o,
  input logic [2:0]  fmt_o,
  input logic        illegal_o,
  input logic [4:0]  shamt_o
);

  always_comb begin
    // R11
    illegal_zero_chk: assert (!illegal_o || (imm_o == '0 && fmt_o == 3'd0 && shamt_o == '0));
    // R2
    upper_low_chk: assert (fmt_o != 3'd5 || (imm_o[11:0] == '0 && imm_o[31:12] == instr_i[31:12]));
    // R3
    jump_even_chk: assert (fmt_o != 3'd6 || (imm_o[0] == 1'b0 && imm_o[31] == instr_i[31]));
    // R4
    branch_even_chk: assert (fmt_o != 3'd4 || (imm_o[0] == 1'b0 && imm_o[31:12] == {20{instr_i[31]}}));
    // R6
    itype_sign_chk: assert (fmt_o != 3'd2 || imm_o[31:11] == {21{instr_i[31]}});
    // R5
    store_sign_chk: assert (fmt_o != 3'd3 || imm_o[31:11] == {21{instr_i[31]}});
    // R9
    zimm_width_chk: assert (fmt_o != 3'd7 || imm_o[31:5] == '0);
    // R10
    reg_noimm_chk: assert (fmt_o != 3'd1 || imm_o == '0);
    // R7
    shamt_scope_chk: assert (shamt_o == '0 || (fmt_o == 3'd2 && instr_i[6:0] == 7'b0010011));
  end

endmodule

bind imm_extract imm_extract_chk u_chk (
  .instr_i   (instr_i),
  .imm_o     (imm_o),
  .fmt_o     (fmt_o),
  .illegal_o (illegal_o),
  .shamt_o   (shamt_o)
);

// File: tb/imm_extract_tb.sv
module imm_extract_tb;

  localparam int NV = 29;
  localparam int WD_CYC = 200000;

  // vector table: word, immediate, format, illegal, shift amount, requirement
  localparam logic [31:0] T_IN [NV] = '{
    32'h123450B7, 32'hFFFFF017, 32'hABCDEFB7,                           // R2
    32'h0010006F, 32'h000FF06F, 32'hFFFFF06F, 32'h7FE0006F,             // R3
    32'h000000E3, 32'hFE000FE3, 32'h00000F63,                           // R4
    32'hFE20AE23, 32'h120021A3,                                         // R5
    32'hFFF00093, 32'h7FF00093, 32'h80002083, 32'h00C08067,             // R6
    32'h01F09093, 32'h40505013,                                         // R7
    32'h40001013, 32'h02005013,                                         // R8
    32'h305FD073, 32'hFFF0F073,                                         // R9
    32'h305F9073, 32'h002081B3, 32'h0FF0000F, 32'h00000073,             // R10
    32'hFFFFFFFF, 32'h00000000, 32'h0000007B                            // R11
  };
  localparam logic [31:0] T_IMM [NV] = '{
    32'h12345000, 32'hFFFFF000, 32'hABCDE000,
    32'h00000800, 32'h000FF000, 32'hFFFFFFFE, 32'h000007FE,
    32'h00000800, 32'hFFFFFFFE, 32'h0000001E,
    32'hFFFFFFFC, 32'h00000123,
    32'hFFFFFFFF, 32'h000007FF, 32'hFFFFF800, 32'h0000000C,
    32'h0000001F, 32'h00000405,
    32'h00000000, 32'h00000000,
    32'h0000001F, 32'h00000001,
    32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000,
    32'h00000000, 32'h00000000, 32'h00000000
  };
  localparam logic [2:0] T_FMT [NV] = '{
    3'd5, 3'd5, 3'd5,
    3'd6, 3'd6, 3'd6, 3'd6,
    3'd4, 3'd4, 3'd4,
    3'd3, 3'd3,
    3'd2, 3'd2, 3'd2, 3'd2,
    3'd2, 3'd2,
    3'd0, 3'd0,
    3'd7, 3'd7,
    3'd1, 3'd1, 3'd1, 3'd1,
    3'd0, 3'd0, 3'd0
  };
  localparam logic T_ILL [NV] = '{
    1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0,
    1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0,
    1'b1, 1'b1,
    1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b1
  };
  localparam logic [4:0] T_SH [NV] = '{
    5'd0, 5'd0, 5'd0,
    5'd0, 5'd0, 5'd0, 5'd0,
    5'd0, 5'd0, 5'd0,
    5'd0, 5'd0,
    5'd0, 5'd0, 5'd0, 5'd0,
    5'd31, 5'd5,
    5'd0, 5'd0,
    5'd0, 5'd0,
    5'd0, 5'd0, 5'd0, 5'd0,
    5'd0, 5'd0, 5'd0
  };
  localparam int T_REQ [NV] = '{
    2, 2, 2,
    3, 3, 3, 3,
    4, 4, 4,
    5, 5,
    6, 6, 6, 6,
    7, 7,
    8, 8,
    9, 9,
    10, 10, 10, 10,
    11, 11, 11
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] imm;
  logic [2:0]  fmt;
  logic        ill;
  logic [4:0]  shamt;

  int n_checks;
  int n_fail;
  bit done;

  imm_extract u_dut (
    .instr_i   (instr),
    .imm_o     (imm),
    .fmt_o     (fmt),
    .illegal_o (ill),
    .shamt_o   (shamt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s word=%h actual=%h expected=%h", req, what, instr, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic [31:0] e_imm,
                           input logic [2:0] e_fmt, input logic e_ill,
                           input logic [4:0] e_sh);
    check(req, "imm", imm, e_imm);
    check(req, "fmt", {29'd0, fmt}, {29'd0, e_fmt});
    check(req, "illegal", {31'd0, ill}, {31'd0, e_ill});
    check(req, "shamt", {27'd0, shamt}, {27'd0, e_sh});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired before completion");
      finish_run();
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    instr    = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: all-zero word during reset decodes as unrecognised
    check_all("R11", 32'h0, 3'd0, 1'b1, 5'd0);
    rst_n = 1'b1;

    // table walk, R1 format codes are checked on every row
    for (int k = 0; k < NV; k++) begin
      string tag;
      apply(T_IN[k]);
      tag = $sformatf("R%0d", T_REQ[k]);
      check_all(tag, T_IMM[k], T_FMT[k], T_ILL[k], T_SH[k]);
    end

    // R2: single bit walked through the upper field
    for (int b = 12; b < 32; b++) begin
      apply(32'h00000037 | (32'h1 << b));
      check("R2", "walk", imm, 32'h1 << b);
    end

    // R6: single bit walked through the register-immediate field
    for (int b = 20; b < 32; b++) begin
      logic [31:0] e;
      e = (b == 31) ? 32'hFFFFF800 : (32'h1 << (b - 20));
      apply(32'h00000013 | (32'h1 << b));
      check("R6", "walk", imm, e);
    end

    // R12: bits outside the store fields (rs1, rs2, funct3) do not move the immediate
    apply(32'h120021A3 | 32'h01FFF000);
    check("R12", "imm", imm, 32'h00000123);
    // R12: same word twice in a row gives the same result
    apply(32'hFE000FE3);
    apply(32'hFE000FE3);
    check("R12", "imm", imm, 32'hFFFFFFFE);

    // R7: shift amount stays zero for a non-shift register-immediate word
    apply(32'h01F00013);
    check("R7", "shamt", {27'd0, shamt}, 32'd0);
    // R9: zimm uses no sign extension even with bit 31 set
    apply(32'hFFFFE073);
    check("R9", "imm", imm, 32'h0000001F);

    done = 1'b1;
    finish_run();
  end

endmodule